// File: doc/BRIEF.md
# Serial Port Register and FIFO Control Unit

This unit is the bus-facing half of a serial port. A simple single-cycle register bus selects one of eight byte offsets. Behind those offsets sit the framing configuration, the enables, the latched receive errors, a data port, the baud divisor and the FIFO controls. Writes to the data offset fill a transmit FIFO, which a serial frame engine drains through a valid/ready stream. Characters that the engine delivers, with their error flags, fill a receive FIFO, which bus reads at the data offset drain. One register reports both fill levels. Two interrupt lines, one for receive and one for transmit, summarise the state for software.

Transmit stream rules: `tx_valid` is high while transmit is enabled and the transmit FIFO holds a byte. `tx_data` shows the oldest byte and stays unchanged until a cycle in which `tx_valid` and `tx_ready` are both high. That cycle consumes the byte. The receive stream has no back-pressure. A `rx_valid` pulse while receive is enabled offers one character. If the receive FIFO is full, the character is lost and overrun is recorded. Bus reads return data combinationally in the cycle `bus_sel` is high. Any side effect of a read or write takes place at the closing clock edge. The FIFO depth is the parameter `DEPTH`, which may be at most 255.

Top module: `sio_ctrl_unit`

## Requirements
- R1: After reset the status register reads 0x0003 (with `tx_idle` high), the FIFO control register reads 0x0400, the byte count reads 0, and both interrupt lines are low.
- R2: Offset 0 (framing mode, 8 bit), offset 2 (extended framing, 8 bit) and offset 6 (baud divisor, 16 bit) read back what was written, and they drive `cfg_mode`, `cfg_ext` and `cfg_baud`. Offset 1 (control) reads back bits 0 to 4: bit 0 transmit enable, bit 1 receive enable, bit 2 idle interrupt enable, bit 3 transmit-empty interrupt enable, bit 4 receive interrupt enable. Offsets with no register read 0.
- R3: A write to offset 4 pushes its low byte into the transmit FIFO. A push to a full FIFO is dropped. Offset 14 bits 7:0 give the transmit fill count. Status bit 1 is high while the transmit FIFO is not full.
- R4: The transmit FIFO is offered to the engine in write order, and only while control bit 0 is set.
- R5: A character arriving while control bit 1 is clear is ignored. Otherwise it is pushed into the receive FIFO. A read of offset 4 returns and pops the oldest character, or returns 0 when the FIFO is empty. Offset 14 bits 15:8 give the receive fill count. Status bit 2 is high while the receive FIFO is not empty.
- R6: A character arriving with receive enabled while the receive FIFO is full is dropped and sets overrun (status bit 3).
- R7: A frame error, a parity error or a break flag on an accepted character latches status bit 4, bit 5 or bit 8 respectively. These bits and overrun stay set until a status write with bit 7 high. Popping the character does not clear them.
- R8: In the FIFO control register (offset 12), writing 1 to bit 2 empties the transmit FIFO and writing 1 to bit 3 empties the receive FIFO. Writing 1 to control bit 7 empties both FIFOs and clears all latched errors. None of these clear bits reads back as 1.
- R9: A FIFO whose enable (FIFO control bit 0 for transmit, bit 1 for receive) is clear holds at most one entry.
- R10: The transmit request flag (FIFO control bit 10) is set in the cycle after the transmit FIFO goes from non-empty to empty. A FIFO control write with bit 10 at 0 clears it. A write with 1 has no effect.
- R11: `irq_tx` is high when any of these holds: the request flag and FIFO control bit 9 are both set; control bit 2 is set and the transmitter is idle (`tx_idle` high and transmit FIFO empty, status bit 0); control bit 3 is set and the transmit FIFO is empty.
- R12: `irq_rx` is high when control bit 4 is set and either the receive FIFO is not empty or an error flag is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_sel is high |
| cfg_mode | output | 8 | Framing mode register to the engine |
| cfg_ext | output | 8 | Extended framing register to the engine |
| cfg_baud | output | 16 | Baud divisor to the engine |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Engine takes the offered byte |
| tx_data | output | 8 | Offered transmit byte |
| tx_idle | input | 1 | Engine has no frame in flight |
| rx_valid | input | 1 | Received character pulse |
| rx_data | input | 8 | Received character |
| rx_frame_err | input | 1 | Frame error on this character |
| rx_parity_err | input | 1 | Parity error on this character |
| rx_break | input | 1 | Break detected with this character |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
A wrong fill count shows at offset 14 on the next read. It also shows on the stream: bytes missing, repeated or reordered among the bytes the engine takes, or bytes returned from the data offset out of arrival order. These appear within one drain of the FIFO. A stuck or lost error latch shows in the status word and in `irq_rx` one cycle after the offending character or clearing write. A request flag that sets on the wrong event shows as `irq_tx` rising or staying low one cycle after the last byte leaves or after a FIFO control write. The random phase mixes arrivals, reads and overruns at a depth of 8 so that the wrap and full boundaries are crossed repeatedly.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [3:0] OFS_MODE  = 4'd0;
  localparam logic [3:0] OFS_CTRL  = 4'd1;
  localparam logic [3:0] OFS_EXT   = 4'd2;
  localparam logic [3:0] OFS_STAT  = 4'd3;
  localparam logic [3:0] OFS_DATA  = 4'd4;
  localparam logic [3:0] OFS_BAUD  = 4'd6;
  localparam logic [3:0] OFS_FCTL  = 4'd12;
  localparam logic [3:0] OFS_FCNT  = 4'd14;

  // control register
  localparam int C_TXEN  = 0;
  localparam int C_RXEN  = 1;
  localparam int C_IDLIE = 2;
  localparam int C_TEMIE = 3;
  localparam int C_RXIE  = 4;
  localparam int C_RESET = 7;

  // status register
  localparam int S_ERRCLR = 7;

  // FIFO control register
  localparam int F_TXEN  = 0;
  localparam int F_RXEN  = 1;
  localparam int F_TXCLR = 2;
  localparam int F_RXCLR = 3;
  localparam int F_REQIE = 9;
  localparam int F_REQ   = 10;
  localparam int F_IDLE  = 11;

  typedef struct packed {
    logic brk;
    logic par;
    logic frm;
    logic ovr;
  } err_flags_t;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 128,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             single,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = single ? (cnt != '0) : (cnt == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sio_err_latch.sv
module sio_err_latch
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  err_flags_t set,
  output err_flags_t flags
);
  // a new event in the clearing cycle survives the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= '0;
    else if (clr) flags <= set;
    else          flags <= flags | set;
  end
endmodule

// File: rtl/sio_irq_gen.sv
module sio_irq_gen
  import sio_pkg::*;
(
  input  logic       req_flag,
  input  logic       req_ie,
  input  logic       idle_ie,
  input  logic       empty_ie,
  input  logic       rx_ie,
  input  logic       tx_bus_idle,
  input  logic       tx_empty,
  input  logic       rx_empty,
  input  err_flags_t errs,
  output logic       irq_tx,
  output logic       irq_rx
);
  always_comb begin
    irq_tx = (req_flag & req_ie) | (idle_ie & tx_bus_idle) | (empty_ie & tx_empty);
    irq_rx = rx_ie & (~rx_empty | (|errs));
  end
endmodule

// File: rtl/sio_ctrl_unit.sv
module sio_ctrl_unit
  import sio_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic [7:0]  cfg_mode,
  output logic [7:0]  cfg_ext,
  output logic [15:0] cfg_baud,
  output logic        tx_en,
  output logic        rx_en,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        tx_idle,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_frame_err,
  input  logic        rx_parity_err,
  input  logic        rx_break,
  output logic        irq_rx,
  output logic        irq_tx
);
  localparam int CW = $clog2(DEPTH + 1);

  // ---------------- bus decode ----------------
  logic wr_hit, rd_hit;
  logic wr_mode, wr_ctrl, wr_ext, wr_stat, wr_data, wr_baud, wr_fctl;
  logic rd_data;

  assign wr_hit  = bus_sel & bus_wr;
  assign rd_hit  = bus_sel & ~bus_wr;
  assign wr_mode = wr_hit & (bus_addr == OFS_MODE);
  assign wr_ctrl = wr_hit & (bus_addr == OFS_CTRL);
  assign wr_ext  = wr_hit & (bus_addr == OFS_EXT);
  assign wr_stat = wr_hit & (bus_addr == OFS_STAT);
  assign wr_data = wr_hit & (bus_addr == OFS_DATA);
  assign wr_baud = wr_hit & (bus_addr == OFS_BAUD);
  assign wr_fctl = wr_hit & (bus_addr == OFS_FCTL);
  assign rd_data = rd_hit & (bus_addr == OFS_DATA);

  // ---------------- configuration registers ----------------
  logic [7:0]  mode_q, ext_q;
  logic [15:0] baud_q;
  logic [4:0]  ctrl_q;
  logic [1:0]  fifo_en_q;
  logic        req_ie_q, idle_ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      ext_q     <= '0;
      baud_q    <= '0;
      ctrl_q    <= '0;
      fifo_en_q <= '0;
      req_ie_q  <= 1'b0;
      idle_ie_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata[7:0];
      if (wr_ext)  ext_q  <= bus_wdata[7:0];
      if (wr_baud) baud_q <= bus_wdata;
      if (wr_ctrl) ctrl_q <= bus_wdata[4:0];
      if (wr_fctl) begin
        fifo_en_q <= {bus_wdata[F_RXEN], bus_wdata[F_TXEN]};
        req_ie_q  <= bus_wdata[F_REQIE];
        idle_ie_q <= bus_wdata[F_IDLE];
      end
    end
  end

  assign cfg_mode = mode_q;
  assign cfg_ext  = ext_q;
  assign cfg_baud = baud_q;
  assign tx_en    = ctrl_q[C_TXEN];
  assign rx_en    = ctrl_q[C_RXEN];

  // ---------------- clears ----------------
  logic port_reset, tx_clr, rx_clr, err_clr;

  assign port_reset = wr_ctrl & bus_wdata[C_RESET];
  assign tx_clr     = port_reset | (wr_fctl & bus_wdata[F_TXCLR]);
  assign rx_clr     = port_reset | (wr_fctl & bus_wdata[F_RXCLR]);
  assign err_clr    = port_reset | (wr_stat & bus_wdata[S_ERRCLR]);

  // ---------------- FIFOs ----------------
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0]    rx_head;
  logic          tx_pop, rx_in;

  assign tx_valid = tx_en & ~tx_empty;
  assign tx_pop   = tx_valid & tx_ready;
  assign rx_in    = rx_valid & rx_en;

  sio_fifo #(.WIDTH(8), .DEPTH(DEPTH), .CW(CW)) u_txq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tx_clr),
    .single (~fifo_en_q[0]),
    .push   (wr_data),
    .wdata  (bus_wdata[7:0]),
    .pop    (tx_pop),
    .rdata  (tx_data),
    .count  (tx_cnt),
    .full   (tx_full),
    .empty  (tx_empty)
  );

  sio_fifo #(.WIDTH(8), .DEPTH(DEPTH), .CW(CW)) u_rxq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (rx_clr),
    .single (~fifo_en_q[1]),
    .push   (rx_in),
    .wdata  (rx_data),
    .pop    (rd_data),
    .rdata  (rx_head),
    .count  (rx_cnt),
    .full   (rx_full),
    .empty  (rx_empty)
  );

  // ---------------- error latches ----------------
  err_flags_t err_set, errs;

  always_comb begin
    err_set.ovr = rx_in & rx_full;
    err_set.frm = rx_in & rx_frame_err;
    err_set.par = rx_in & rx_parity_err;
    err_set.brk = rx_in & rx_break;
  end

  sio_err_latch u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (err_clr),
    .set   (err_set),
    .flags (errs)
  );

  // ---------------- transmit request flag ----------------
  logic tx_going_empty, req_q;

  assign tx_going_empty = (tx_cnt == CW'(1) && tx_pop && !(wr_data && !tx_full))
                        | (tx_clr & ~tx_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            req_q <= 1'b1;
    else if (tx_going_empty)               req_q <= 1'b1;
    else if (wr_fctl && !bus_wdata[F_REQ]) req_q <= 1'b0;
  end

  // ---------------- interrupts ----------------
  logic tx_bus_idle;
  assign tx_bus_idle = tx_idle & tx_empty;

  sio_irq_gen u_irq (
    .req_flag    (req_q),
    .req_ie      (req_ie_q),
    .idle_ie     (ctrl_q[C_IDLIE]),
    .empty_ie    (ctrl_q[C_TEMIE]),
    .rx_ie       (ctrl_q[C_RXIE]),
    .tx_bus_idle (tx_bus_idle),
    .tx_empty    (tx_empty),
    .rx_empty    (rx_empty),
    .errs        (errs),
    .irq_tx      (irq_tx),
    .irq_rx      (irq_rx)
  );

  // ---------------- read mux ----------------
  logic [15:0] stat_word, fctl_word, fcnt_word;

  assign stat_word = {7'b0, errs.brk, 2'b0, errs.par, errs.frm, errs.ovr,
                      ~rx_empty, ~tx_full, tx_bus_idle};
  assign fctl_word = {4'b0, idle_ie_q, req_q, req_ie_q, 7'b0, fifo_en_q};
  assign fcnt_word = {8'(rx_cnt), 8'(tx_cnt)};

  always_comb begin
    unique case (bus_addr)
      OFS_MODE: bus_rdata = {8'b0, mode_q};
      OFS_CTRL: bus_rdata = {11'b0, ctrl_q};
      OFS_EXT:  bus_rdata = {8'b0, ext_q};
      OFS_STAT: bus_rdata = stat_word;
      OFS_DATA: bus_rdata = rx_empty ? 16'h0 : {8'b0, rx_head};
      OFS_BAUD: bus_rdata = baud_q;
      OFS_FCTL: bus_rdata = fctl_word;
      OFS_FCNT: bus_rdata = fcnt_word;
      default:  bus_rdata = 16'h0;
    endcase
  end
endmodule

// File: rtl/sio_ctrl_unit_chk.sv
module sio_ctrl_unit_chk #(
  parameter int DEPTH = 128,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_en,
  input logic          rx_valid,
  input logic          rx_en,
  input logic          rx_frame_err,
  input logic          rx_full,
  input logic          rx_ie,
  input logic          irq_rx,
  input logic          req_q,
  input logic          frm_q,
  input logic          ovr_q,
  input logic [CW-1:0] tx_cnt
);
  // R4
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_en);

  // R3
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  // R10
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(tx_cnt) != '0);

  // R7
  frame_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_en && rx_frame_err) |=> frm_q);

  // R6
  overrun_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_en && rx_full) |=> ovr_q);

  // R12
  rx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |-> !irq_rx);
endmodule

bind sio_ctrl_unit sio_ctrl_unit_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_valid     (tx_valid),
  .tx_en        (tx_en),
  .rx_valid     (rx_valid),
  .rx_en        (rx_en),
  .rx_frame_err (rx_frame_err),
  .rx_full      (rx_full),
  .rx_ie        (ctrl_q[4]),
  .irq_rx       (irq_rx),
  .req_q        (req_q),
  .frm_q        (errs.frm),
  .ovr_q        (errs.ovr),
  .tx_cnt       (tx_cnt)
);

// File: tb/sio_ctrl_unit_tb.sv
module sio_ctrl_unit_tb;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [7:0]  cfg_mode, cfg_ext;
  logic [15:0] cfg_baud;
  logic        tx_en, rx_en, tx_valid, irq_rx, irq_tx;
  logic        tx_ready = 0, tx_idle = 1;
  logic [7:0]  tx_data;
  logic        rx_valid = 0, rx_frame_err = 0, rx_parity_err = 0, rx_break = 0;
  logic [7:0]  rx_data = 0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sio_ctrl_unit #(.DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_mode(cfg_mode), .cfg_ext(cfg_ext), .cfg_baud(cfg_baud),
    .tx_en(tx_en), .rx_en(rx_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_idle(tx_idle), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err), .rx_break(rx_break),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic rx_put(input logic [7:0] b, input bit fe, input bit pe, input bit bk);
    @(negedge clk);
    rx_valid = 1; rx_data = b; rx_frame_err = fe; rx_parity_err = pe; rx_break = bk;
    @(posedge clk); #1;
    rx_valid = 0; rx_frame_err = 0; rx_parity_err = 0; rx_break = 0;
  endtask

  task automatic read_chk(input string tag, input logic [3:0] a, input int exp);
    logic [15:0] v;
    bus_read(a, v);
    check(tag, int'(v), exp);
  endtask

  function automatic int exp_status(bit idle, bit txfull, bit rxne,
                                    bit ov, bit fr, bit pa, bit bk);
    return (int'(bk) << 8) | (int'(pa) << 5) | (int'(fr) << 4) | (int'(ov) << 3)
         | (int'(rxne) << 2) | (int'(!txfull) << 1) | int'(idle);
  endfunction

  function automatic int exp_count(int rxn, int txn);
    return (rxn << 8) | txn;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] sent [D];
    int got_n;
    int mq[$];
    bit m_ovr;
    logic [15:0] v;
    void'($urandom(32'd2024));

    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // ---- R1 reset state
    read_chk("R1 status", 4'd3, exp_status(1, 0, 0, 0, 0, 0, 0));
    read_chk("R1 fifo ctrl", 4'd12, 16'h0400);
    read_chk("R1 byte count", 4'd14, 0);
    check("R1 irq_rx", int'(irq_rx), 0);
    check("R1 irq_tx", int'(irq_tx), 0);

    // ---- R2 register readback
    bus_write(4'd0, 16'h00A5);
    bus_write(4'd2, 16'h005A);
    bus_write(4'd6, 16'h1234);
    read_chk("R2 mode", 4'd0, 16'h00A5);
    read_chk("R2 ext", 4'd2, 16'h005A);
    read_chk("R2 baud", 4'd6, 16'h1234);
    check("R2 cfg pins", int'({cfg_mode, cfg_ext}), 16'hA55A);
    check("R2 cfg baud pin", int'(cfg_baud), 16'h1234);
    bus_write(4'd1, 16'h001C);
    read_chk("R2 ctrl", 4'd1, 16'h001C);
    read_chk("R2 unmapped", 4'd5, 0);
    bus_write(4'd1, 16'h0000);

    // ---- enable both FIFOs, R10 clear by writing 0
    bus_write(4'd12, 16'h0003);
    read_chk("R10 req cleared", 4'd12, 16'h0003);

    // ---- R3 transmit fill and drop
    for (int i = 0; i < D; i++) begin
      sent[i] = 8'($urandom);
      bus_write(4'd4, {8'h0, sent[i]});
    end
    bus_write(4'd4, 16'h00EE);
    read_chk("R3 tx count full", 4'd14, exp_count(0, D));
    read_chk("R3 status full", 4'd3, exp_status(0, 1, 0, 0, 0, 0, 0));
    @(negedge clk);
    check("R4 no offer while disabled", int'(tx_valid), 0);

    // ---- R4 drain in order with random ready
    bus_write(4'd1, 16'h0001);
    got_n = 0;
    for (int c = 0; c < 200 && got_n < D; c++) begin
      @(negedge clk);
      tx_ready = 1'($urandom);
      #1;
      if (tx_valid && tx_ready) begin
        check("R4 tx order", int'(tx_data), int'(sent[got_n]));
        got_n++;
      end
      @(posedge clk);
    end
    @(negedge clk); tx_ready = 0;
    check("R4 all bytes out", got_n, D);
    read_chk("R10 req set after drain", 4'd12, 16'h0403);

    // ---- R11 interrupt sources
    bus_write(4'd12, 16'h0603);
    read_chk("R10 write 1 keeps", 4'd12, 16'h0603);
    #1 check("R11 req+ie", int'(irq_tx), 1);
    bus_write(4'd12, 16'h0203);
    read_chk("R10 write 0 clears", 4'd12, 16'h0203);
    bus_write(4'd12, 16'h0603);
    read_chk("R10 write 1 no set", 4'd12, 16'h0203);
    check("R11 req cleared", int'(irq_tx), 0);
    bus_write(4'd1, 16'h0005);
    #1 check("R11 idle ie", int'(irq_tx), 1);
    @(negedge clk); tx_idle = 0; #1;
    check("R11 engine busy", int'(irq_tx), 0);
    bus_write(4'd1, 16'h0009);
    #1 check("R11 empty ie", int'(irq_tx), 1);
    @(negedge clk); tx_idle = 1;
    bus_write(4'd1, 16'h0000);

    // ---- R5 receive ignored when disabled
    rx_put(8'h11, 0, 0, 0);
    read_chk("R5 rx disabled", 4'd14, 0);

    // ---- R5/R6/R12 random receive traffic vs model
    bus_write(4'd1, 16'h0012);
    m_ovr = 0;
    for (int k = 0; k < 400; k++) begin
      if (($urandom % 5) < 3) begin
        logic [7:0] b;
        b = 8'($urandom);
        rx_put(b, 0, 0, 0);
        if (mq.size() < D) mq.push_back(int'(b)); else m_ovr = 1;
      end else begin
        int e;
        e = (mq.size() > 0) ? mq.pop_front() : 0;
        read_chk("R5 rx data", 4'd4, e);
      end
      if (k % 8 == 0) begin
        read_chk("R5 rx count", 4'd14, exp_count(mq.size(), 0));
        read_chk("R6 overrun flag", 4'd3,
                 exp_status(1, 0, mq.size() > 0, m_ovr, 0, 0, 0));
        #1 check("R12 irq_rx", int'(irq_rx), int'(mq.size() > 0 || m_ovr));
      end
    end
    while (mq.size() > 0) read_chk("R5 rx drain", 4'd4, mq.pop_front());
    bus_write(4'd3, 16'h0080);
    read_chk("R7 errors cleared", 4'd3, exp_status(1, 0, 0, 0, 0, 0, 0));
    #1 check("R12 irq_rx low", int'(irq_rx), 0);

    // ---- R7 error latching
    rx_put(8'h41, 1, 0, 0);
    read_chk("R7 frame", 4'd3, exp_status(1, 0, 1, 0, 1, 0, 0));
    read_chk("R7 data", 4'd4, 16'h0041);
    read_chk("R7 frame sticky", 4'd3, exp_status(1, 0, 0, 0, 1, 0, 0));
    #1 check("R12 irq on error", int'(irq_rx), 1);
    bus_write(4'd3, 16'h0080);
    read_chk("R7 clear", 4'd3, exp_status(1, 0, 0, 0, 0, 0, 0));
    rx_put(8'h42, 0, 1, 0);
    rx_put(8'h43, 0, 0, 1);
    read_chk("R7 parity break", 4'd3, exp_status(1, 0, 1, 0, 0, 1, 1));
    bus_write(4'd3, 16'h0080);
    read_chk("R7 clear keeps data", 4'd3, exp_status(1, 0, 1, 0, 0, 0, 0));

    // ---- R8 FIFO clears
    bus_write(4'd12, 16'h000B);
    read_chk("R8 rx clear", 4'd14, 0);
    read_chk("R8 clear bits read 0", 4'd12, 16'h0003);
    bus_write(4'd4, 16'h0001);
    bus_write(4'd4, 16'h0002);
    bus_write(4'd12, 16'h0207);
    read_chk("R8 tx clear", 4'd14, 0);
    read_chk("R10 req on clear", 4'd12, 16'h0603);
    #1 check("R11 irq after clear", int'(irq_tx), 1);

    // ---- R8 port reset through control bit 7
    bus_write(4'd4, 16'h0005);
    rx_put(8'h66, 0, 1, 0);
    bus_write(4'd1, 16'h0080);
    read_chk("R8 reset counts", 4'd14, 0);
    read_chk("R8 reset errors", 4'd3, exp_status(1, 0, 0, 0, 0, 0, 0));
    read_chk("R8 ctrl after reset", 4'd1, 0);

    // ---- R9 FIFOs disabled hold one entry
    bus_write(4'd12, 16'h0000);
    bus_write(4'd1, 16'h0002);
    bus_write(4'd4, 16'h0031);
    bus_write(4'd4, 16'h0032);
    rx_put(8'h51, 0, 0, 0);
    rx_put(8'h52, 0, 0, 0);
    read_chk("R9 single counts", 4'd14, exp_count(1, 1));
    read_chk("R9 single overrun", 4'd3, exp_status(0, 1, 1, 1, 0, 0, 0));
    bus_read(4'd4, v);
    check("R9 first kept", int'(v), 16'h0051);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule